// File: doc/BRIEF.md
# Flash Read Data Multiplexer

This block produces the data returned by a parallel NOR flash on every host read. A separate command sequencer publishes which kind of read is active: plain array data, the identification view, the busy-status view or the query table. From the host offset and access size, the block picks the correct source and assembles a 1-, 2- or 4-byte result in the selected byte order. The result is registered, so it appears one cycle after the read strobe.

Two pieces of state live here. The first is the toggle bit of the status byte, which inverts after every status read so that software can tell an operation is still running. The second is a counter of idle array reads. When it exceeds a threshold, the counter raises `direct_en`, which tells the host that it may return to its fast direct-read path. The array bytes and the query table sit outside the block. The block presents an offset and an index to them and takes their bytes back in the same cycle.

Top module: `flash_read_mux`

## Requirements
- R1: `arr_off` equals `rd_addr` masked to the chip size (`CHIP_BYTES`, a power of two). The word index is the low 8 bits of that offset, shifted right by 1 for halfword access and by 2 for word access. `rd_width` is encoded 0 = byte, 1 = halfword, 2 = word, and 3 is handled as byte. `cfi_idx` presents the word index.
- R2: `arr_bytes[8k+7:8k]` holds the byte at offset+k. In array mode (`mode` 0) and erase-setup mode (`mode` 1), a byte read returns byte 0 zero-extended. With `big_end` = 0, wider reads put byte 0 in the least significant position; with `big_end` = 1, byte 0 goes in the most significant position of the 16- or 32-bit result.
- R3: In identification mode (`mode` 2), index 0 returns `ID0`, index 1 returns `ID1` and index 2 returns 0 (no sector protected).
- R4: In identification mode, index 0x0E returns `ID2` and index 0x0F returns `ID3`, unless that ID equals 0x00FF, in which case array data is returned. Every other index returns array data.
- R5: In busy mode (`mode` 3), a read returns `{stat_in[7], toggle, stat_in[5:0]}`, and the toggle (visible on `stat_tog`) inverts after each such read. The toggle resets to 0 and changes on no other read.
- R6: In query mode (`mode` 4), a read returns `cfi_byte` when the index is at most `CFI_LEN` (0x52), and 0 when the index is greater.
- R7: `direct_en` resets to 1. `cmd_start` clears it and clears the read counter. While `direct_en` is 0, each read in mode 0 advances the counter. The read that takes the count above `THRESH` (42) sets `direct_en`, so this is read number 43. Reads in other modes do not count. `cmd_start` takes priority over a read in the same cycle.
- R8: A read in an undefined mode (5 to 7) returns array data and raises `mode_err` for exactly that one result cycle.
- R9: `rd_valid` is high exactly in the cycle after `rd_en`. `rd_data` changes only when a read is registered. After reset, `rd_data` is 0 and `rd_valid`, `mode_err` and `stat_tog` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Host byte offset |
| rd_width | input | 2 | Access size code |
| big_end | input | 1 | Byte order select, 1 = big-endian |
| mode | input | 3 | Read mode from the command sequencer |
| cmd_start | input | 1 | A command write started; disables the direct path |
| stat_in | input | 8 | Status byte from the sequencer (bit 6 replaced) |
| arr_off | output | ADDR_W | Masked byte offset into the array |
| arr_bytes | input | 32 | Array bytes at arr_off..arr_off+3 |
| cfi_idx | output | 8 | Query table index |
| cfi_byte | input | 8 | Query table entry at cfi_idx |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | rd_data holds a new result |
| mode_err | output | 1 | Result was produced for an undefined mode |
| direct_en | output | 1 | Fast direct-read path may be used |
| stat_tog | output | 1 | Current status toggle bit |

## Verification
The hardest state to reach is the edge of the direct-path counter. The block must stay disabled for exactly 42 idle array reads after a command and enable on the 43rd. The stimulus issues `cmd_start` and then a long run of mode-0 reads. That run is interleaved with status, query and erase-setup reads, which must not count, and with a second `cmd_start` partway through that must restart the count. A behavioural model in the bench tracks the counter and the toggle as plain integers and compares every output on every clock.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [2:0] {
        MD_ARRAY   = 3'd0,
        MD_ERSETUP = 3'd1,
        MD_IDREAD  = 3'd2,
        MD_BUSY    = 3'd3,
        MD_QUERY   = 3'd4
    } rd_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } rd_size_e;

    localparam int WORD_W = 32;

endpackage

// File: rtl/flash_rd_index.sv
module flash_rd_index
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CHIP_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] off,
    output logic [7:0]        idx
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(CHIP_BYTES - 1);

    always_comb begin
        off = addr & OFF_MASK;
        case (size)
            SZ_HALF: idx = {1'b0, off[7:1]};
            SZ_WORD: idx = {2'b00, off[7:2]};
            default: idx = off[7:0];
        endcase
    end
endmodule

// File: rtl/flash_rd_pack.sv
module flash_rd_pack
    import flash_rd_pkg::*;
(
    input  logic [31:0] bytes_in,
    input  logic [1:0]  size,
    input  logic        big_end,
    output logic [31:0] word
);
    logic [7:0] b [4];

    for (genvar k = 0; k < 4; k++) begin : g_split
        assign b[k] = bytes_in[8*k +: 8];
    end

    always_comb begin
        case (size)
            SZ_HALF: word = big_end ? {16'd0, b[0], b[1]} : {16'd0, b[1], b[0]};
            SZ_WORD: word = big_end ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
            default: word = {24'd0, b[0]};
        endcase
    end
endmodule

// File: rtl/flash_rd_idsel.sv
module flash_rd_idsel #(
    parameter logic [15:0] ID0 = 16'h0001,
    parameter logic [15:0] ID1 = 16'h227E,
    parameter logic [15:0] ID2 = 16'h2210,
    parameter logic [15:0] ID3 = 16'h00FF
) (
    input  logic [7:0]  idx,
    input  logic [31:0] arr_word,
    output logic [31:0] id_word
);
    localparam logic [15:0] NO_ID = 16'h00FF;

    always_comb begin
        case (idx)
            8'h00:   id_word = {16'd0, ID0};
            8'h01:   id_word = {16'd0, ID1};
            8'h02:   id_word = 32'd0;
            8'h0E:   id_word = (ID2 == NO_ID) ? arr_word : {16'd0, ID2};
            8'h0F:   id_word = (ID3 == NO_ID) ? arr_word : {16'd0, ID3};
            default: id_word = arr_word;
        endcase
    end
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_rd_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          CHIP_BYTES = 4096,
    parameter int          THRESH     = 42,
    parameter logic [7:0]  CFI_LEN    = 8'h52,
    parameter logic [15:0] ID0        = 16'h0001,
    parameter logic [15:0] ID1        = 16'h227E,
    parameter logic [15:0] ID2        = 16'h2210,
    parameter logic [15:0] ID3        = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_width,
    input  logic              big_end,
    input  logic [2:0]        mode,
    input  logic              cmd_start,
    input  logic [7:0]        stat_in,
    output logic [ADDR_W-1:0] arr_off,
    input  logic [31:0]       arr_bytes,
    output logic [7:0]        cfi_idx,
    input  logic [7:0]        cfi_byte,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              mode_err,
    output logic              direct_en,
    output logic              stat_tog
);
    localparam int CW = $clog2(THRESH + 2);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              err;
        logic              tog;
        logic              den;
        logic [CW-1:0]     cnt;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [7:0]  idx;
    logic [31:0] arr_word, id_word;

    flash_rd_index #(.ADDR_W(ADDR_W), .CHIP_BYTES(CHIP_BYTES)) u_index (
        .addr(rd_addr), .size(rd_width), .off(arr_off), .idx(idx)
    );

    flash_rd_pack u_pack (
        .bytes_in(arr_bytes), .size(rd_width), .big_end(big_end), .word(arr_word)
    );

    flash_rd_idsel #(.ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_idsel (
        .idx(idx), .arr_word(arr_word), .id_word(id_word)
    );

    assign cfi_idx = idx;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en;
        st_d.err   = 1'b0;
        if (rd_en) begin
            case (rd_mode_e'(mode))
                MD_ARRAY, MD_ERSETUP: st_d.data = arr_word;
                MD_IDREAD:            st_d.data = id_word;
                MD_BUSY: begin
                    st_d.data = {24'd0, stat_in[7], st_q.tog, stat_in[5:0]};
                    st_d.tog  = ~st_q.tog;
                end
                MD_QUERY:  st_d.data = (idx > CFI_LEN) ? 32'd0 : {24'd0, cfi_byte};
                default: begin
                    st_d.data = arr_word;
                    st_d.err  = 1'b1;
                end
            endcase
        end
        if (cmd_start) begin
            st_d.den = 1'b0;
            st_d.cnt = '0;
        end else if (rd_en && (mode == MD_ARRAY) && !st_q.den) begin
            st_d.cnt = CW'(st_q.cnt + 1'b1);
            if (st_q.cnt >= CW'(THRESH)) st_d.den = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.den  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.data;
    assign rd_valid  = st_q.valid;
    assign mode_err  = st_q.err;
    assign direct_en = st_q.den;
    assign stat_tog  = st_q.tog;

    // R9: result appears exactly one cycle after the strobe
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data)));
    // R5: each busy read flips the toggle
    a_r5_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == 3'd3) |=> (stat_tog != $past(stat_tog)));
    a_r5_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && mode == 3'd3) |=> $stable(stat_tog));
    // R7: command start closes the direct path
    a_r7_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !direct_en);
    // R6: out-of-table query reads return zero
    a_r6_query_beyond: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == 3'd4 && cfi_idx > CFI_LEN) |=> (rd_data == 32'd0));
    // R8: error flag only accompanies a result
    a_r8_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> rd_valid);
endmodule

// File: tb/flash_read_mux_bench.sv
module flash_read_mux_bench;
    localparam int AW = 16;
    localparam int CHIP = 4096;
    localparam logic [15:0] I0 = 16'h0001, I1 = 16'h227E, I2 = 16'h2210, I3 = 16'h00FF;

    logic clk = 0, rst_n = 0;
    logic rd_en = 0, big_end = 0, cmd_start = 0;
    logic [AW-1:0] rd_addr = '0;
    logic [1:0] rd_width = 0;
    logic [2:0] mode = 0;
    logic [7:0] stat_in = 0, cfi_byte;
    logic [31:0] arr_bytes;
    logic [AW-1:0] arr_off;
    logic [7:0] cfi_idx;
    logic [31:0] rd_data;
    logic rd_valid, mode_err, direct_en, stat_tog;

    int checks = 0, fails = 0;
    int m_tog = 0, m_den = 1, m_cnt = 0;

    always #4 clk = ~clk;

    flash_read_mux u_flash_read_mux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_width(rd_width),
        .big_end(big_end), .mode(mode), .cmd_start(cmd_start), .stat_in(stat_in),
        .arr_off(arr_off), .arr_bytes(arr_bytes), .cfi_idx(cfi_idx), .cfi_byte(cfi_byte),
        .rd_data(rd_data), .rd_valid(rd_valid), .mode_err(mode_err),
        .direct_en(direct_en), .stat_tog(stat_tog)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + (a >> 8) + 3) & 255);
    endfunction

    // external memories respond to the offset/index the bench expects
    always_comb begin
        int o;
        o = int'(rd_addr) % CHIP;
        arr_bytes = {pat((o + 3) % CHIP), pat((o + 2) % CHIP), pat((o + 1) % CHIP), pat(o)};
        cfi_byte = cfi_idx ^ 8'hA5;
    end

    function automatic int word_idx(int a, int w);
        int low;
        low = (a % CHIP) & 255;
        if (w == 1) return low / 2;
        if (w == 2) return low / 4;
        return low;
    endfunction

    function automatic logic [31:0] arr_val(int a, int w, logic be);
        int o;
        logic [7:0] b0, b1, b2, b3;
        o = a % CHIP;
        b0 = pat(o); b1 = pat((o + 1) % CHIP); b2 = pat((o + 2) % CHIP); b3 = pat((o + 3) % CHIP);
        if (w == 1) return be ? {16'd0, b0, b1} : {16'd0, b1, b0};
        if (w == 2) return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
        return {24'd0, b0};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [31:0] e_data = 0;

    task automatic cyc(string req, logic en, int a, int w, logic be, int md, logic cs, logic [7:0] st);
        logic e_err;
        int ix;
        rd_en = en; rd_addr = AW'(a); rd_width = 2'(w); big_end = be; mode = 3'(md);
        cmd_start = cs; stat_in = st;
        e_err = 0;
        ix = word_idx(a, w);
        #1;
        if (en) chk(req, "cfi_idx", {24'd0, cfi_idx}, 32'(ix));
        if (en) begin
            case (md)
                0, 1: e_data = arr_val(a, w, be);
                2: begin
                    if (ix == 0) e_data = {16'd0, I0};
                    else if (ix == 1) e_data = {16'd0, I1};
                    else if (ix == 2) e_data = 0;
                    else if (ix == 14 && I2 != 16'h00FF) e_data = {16'd0, I2};
                    else if (ix == 15 && I3 != 16'h00FF) e_data = {16'd0, I3};
                    else e_data = arr_val(a, w, be);
                end
                3: begin
                    e_data = {24'd0, st[7], 1'(m_tog), st[5:0]};
                    m_tog = 1 - m_tog;
                end
                4: e_data = (ix > 8'h52) ? 0 : 32'(8'(ix) ^ 8'hA5);
                default: begin e_data = arr_val(a, w, be); e_err = 1; end
            endcase
        end
        if (cs) begin m_den = 0; m_cnt = 0; end
        else if (en && md == 0 && m_den == 0) begin
            m_cnt++;
            if (m_cnt > 42) m_den = 1;
        end
        @(negedge clk);
        chk(req, "rd_valid", {31'd0, rd_valid}, {31'd0, en});
        chk(req, "rd_data", rd_data, e_data);
        chk(req, "mode_err", {31'd0, mode_err}, {31'd0, e_err});
        chk("R7", "direct_en", {31'd0, direct_en}, 32'(m_den));
        chk("R5", "stat_tog", {31'd0, stat_tog}, 32'(m_tog));
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "reset rd_data", rd_data, 0);
        chk("R9", "reset rd_valid", {31'd0, rd_valid}, 0);
        chk("R7", "reset direct_en", {31'd0, direct_en}, 1);
        chk("R5", "reset stat_tog", {31'd0, stat_tog}, 0);
        rst_n = 1;
        @(negedge clk);
        // R1 masking and R2 assembly
        cyc("R1", 1, 16'hF123, 0, 0, 0, 0, 0);
        rd_addr = 16'hF123; #1;
        chk("R1", "arr_off", {16'd0, arr_off}, 32'h0123);
        cyc("R2", 1, 16'h0456, 1, 0, 0, 0, 0);
        cyc("R2", 1, 16'h0456, 1, 1, 0, 0, 0);
        cyc("R2", 1, 16'h3A08, 2, 0, 1, 0, 0);
        cyc("R2", 1, 16'h3A08, 2, 1, 1, 0, 0);
        cyc("R9", 0, 16'h0010, 2, 1, 0, 0, 0);
        cyc("R9", 0, 16'h0020, 0, 0, 3, 0, 8'h80);
        // R3/R4 identification
        cyc("R3", 1, 16'h0000, 0, 0, 2, 0, 0);
        cyc("R3", 1, 16'h0002, 1, 0, 2, 0, 0);
        cyc("R3", 1, 16'h0008, 2, 0, 2, 0, 0);
        cyc("R4", 1, 16'h001C, 1, 0, 2, 0, 0);
        cyc("R4", 1, 16'h003C, 2, 1, 2, 0, 0);
        cyc("R4", 1, 16'h0105, 0, 0, 2, 0, 0);
        cyc("R4", 1, 16'h100E, 0, 0, 2, 0, 0);
        // R5 status toggle
        for (int i = 0; i < 4; i++) cyc("R5", 1, 16'h0000, 0, 0, 3, 0, 8'hBF ^ 8'(i));
        // R6 query table
        cyc("R6", 1, 16'h0010, 0, 0, 4, 0, 0);
        cyc("R6", 1, 16'h00A4, 1, 0, 4, 0, 0);
        cyc("R6", 1, 16'h0053, 0, 0, 4, 0, 0);
        cyc("R6", 1, 16'h00FC, 2, 0, 4, 0, 0);
        // R8 undefined modes
        for (int md = 5; md < 8; md++) cyc("R8", 1, 16'h0200 + md, 1, 1, md, 0, 0);
        cyc("R8", 0, 0, 0, 0, 5, 0, 0);
        // R7 counter threshold with restarts and non-counting reads
        cyc("R7", 0, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 20; i++) cyc("R7", 1, 4 * i, 0, 0, 0, 0, 0);
        cyc("R7", 1, 0, 0, 0, 1, 0, 0);
        cyc("R7", 1, 0, 0, 0, 3, 0, 0);
        cyc("R7", 1, 0, 0, 0, 4, 0, 0);
        cyc("R7", 1, 8, 0, 0, 0, 1, 0);
        for (int i = 0; i < 41; i++) cyc("R7", 1, i, 0, 0, 0, 0, 0);
        cyc("R7", 1, 50, 0, 0, 1, 0, 0);
        cyc("R7", 1, 51, 0, 0, 0, 0, 0);
        cyc("R7", 1, 52, 0, 0, 0, 0, 0);
        cyc("R7", 1, 53, 0, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule